// File: doc/BRIEF.md
# Four-Bit Arithmetic/Logic Unit with Carry and Zero Flags

This block is the datapath arithmetic stage of a small accumulator machine. Each cycle it combines the current accumulator value with a second 4-bit operand under a 3-bit operation code. The operand may be an immediate, a register or memory data; the caller selects it. The result appears combinationally, together with a write-back strobe for the accumulator. The carry and zero flags sit in a register inside the block and change only on an enabled clock edge.

Five operations are supported: pass-through (used by accumulator loads), bitwise NAND, addition, subtraction and compare. The carry flag has two meanings. After an addition it holds the carry out. After a subtraction or compare it holds the borrow. Compare changes only the flags and never requests a write-back. Pass-through and NAND refresh the zero flag and keep the carry flag.

Top module: `alu4_flag_unit`

## Requirements
- R1: With op code 0 (pass-through), res_o equals opnd_i and wr_acc_o equals en_i. An enabled edge loads zf_o with (opnd_i == 0) and leaves cf_o unchanged.
- R2: With op code 1 (NAND), res_o is the bitwise NOT of (acc_i AND opnd_i) and wr_acc_o equals en_i. An enabled edge updates zf_o and leaves cf_o unchanged.
- R3: With op code 2 (add), res_o is the low 4 bits of acc_i + opnd_i. An enabled edge sets cf_o to 1 exactly when the 5-bit sum exceeds 15. For example, 1 + 0xF gives res_o 0 with cf_o 1 and zf_o 1.
- R4: With op code 3 (subtract), res_o is acc_i - opnd_i modulo 16. An enabled edge sets cf_o to 1 exactly when opnd_i is greater than acc_i (borrow).
- R5: With op code 4 (compare), res_o shows acc_i - opnd_i modulo 16 and wr_acc_o stays 0. An enabled edge updates cf_o as a borrow and updates zf_o, exactly as for subtract.
- R6: After any enabled edge with op code 0 to 4, zf_o is 1 exactly when the res_o presented before that edge was zero.
- R7: While en_i is low, neither flag changes on a clock edge, and wr_acc_o is 0.
- R8: While rst_n is low, cf_o and zf_o are 0 at once, with no clock needed. After rst_n rises, the first two rising edges leave both flags at 0, and the third enabled edge is the first to update them.
- R9: Op codes 5, 6 and 7 are reserved. res_o equals acc_i, wr_acc_o is 0 and both flags hold their values.
- R10: res_o and wr_acc_o follow the inputs in the same cycle. Flags change only at a rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| en_i | input | 1 | Clock enable for the flag register and the write-back strobe |
| op_i | input | 3 | Operation code (0 pass, 1 NAND, 2 add, 3 subtract, 4 compare, 5 to 7 reserved) |
| acc_i | input | 4 | Accumulator value |
| opnd_i | input | 4 | Second operand |
| res_o | output | 4 | Combinational result |
| wr_acc_o | output | 1 | Accumulator write-back request |
| cf_o | output | 1 | Carry or borrow flag |
| zf_o | output | 1 | Zero flag |

## Verification
The bench sweeps all 256 operand pairs for each operation. This catches a wrapped sum reported without carry, and a borrow taken with the wrong polarity. A borrow of that kind would show up as a set carry flag when the operands are equal. Directed vectors then aim at the flag-holding cases. A NAND or load that disturbed the carry flag, or a reserved code that cleared the zero flag, would break a flag value set up by the previous vector. The vectors also cover the two remaining traps. A compare that asked for a write-back would clobber the accumulator. A disabled edge that moved a flag would corrupt a later conditional branch. The reset test asserts reset between clock edges and then counts the edges after release. This exposes a purely synchronous reset or a synchronizer of the wrong depth.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
  localparam int unsigned DW    = 4;
  localparam int unsigned OPW   = 3;
  localparam int unsigned SYNCN = 2;

  typedef enum logic [OPW-1:0] {
    OP_PASS = 3'd0,
    OP_NAND = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_CMP  = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic upd_cf;
    logic upd_zf;
    logic cf_new;
    logic zf_new;
  } flag_upd_t;
endpackage

// File: rtl/alu4_rst_sync.sv
module alu4_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/alu4_addsub.sv
module alu4_addsub #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0]   carry;
  logic [W-1:0] b_eff;

  assign carry[0] = sub_i;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign b_eff[i]   = b_i[i] ^ sub_i;
    assign sum_o[i]   = a_i[i] ^ b_eff[i] ^ carry[i];
    assign carry[i+1] = (a_i[i] & b_eff[i]) | (carry[i] & (a_i[i] ^ b_eff[i]));
  end

  assign cout_o = carry[W];
endmodule

// File: rtl/alu4_core.sv
module alu4_core
  import alu4_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic [OPW-1:0] op_i,
  input  logic [W-1:0]   acc_i,
  input  logic [W-1:0]   opnd_i,
  output logic [W-1:0]   res_o,
  output logic           writes_o,
  output flag_upd_t      upd_o
);
  logic [W-1:0] nand_v;
  logic [W-1:0] as_sum;
  logic         as_cout;
  logic         is_sub;

  for (genvar i = 0; i < W; i++) begin : g_nand
    assign nand_v[i] = ~(acc_i[i] & opnd_i[i]);
  end

  assign is_sub = (op_i == OP_SUB) || (op_i == OP_CMP);

  alu4_addsub #(.W(W)) u_addsub (
    .a_i    (acc_i),
    .b_i    (opnd_i),
    .sub_i  (is_sub),
    .sum_o  (as_sum),
    .cout_o (as_cout)
  );

  always_comb begin
    res_o         = acc_i;
    writes_o      = 1'b0;
    upd_o.upd_cf  = 1'b0;
    upd_o.upd_zf  = 1'b0;
    upd_o.cf_new  = 1'b0;
    case (op_i)
      OP_PASS: begin
        res_o        = opnd_i;
        writes_o     = 1'b1;
        upd_o.upd_zf = 1'b1;
      end
      OP_NAND: begin
        res_o        = nand_v;
        writes_o     = 1'b1;
        upd_o.upd_zf = 1'b1;
      end
      OP_ADD: begin
        res_o        = as_sum;
        writes_o     = 1'b1;
        upd_o.upd_zf = 1'b1;
        upd_o.upd_cf = 1'b1;
        upd_o.cf_new = as_cout;
      end
      OP_SUB, OP_CMP: begin
        res_o        = as_sum;
        writes_o     = (op_i == OP_SUB);
        upd_o.upd_zf = 1'b1;
        upd_o.upd_cf = 1'b1;
        upd_o.cf_new = ~as_cout;
      end
      default: ;
    endcase
    upd_o.zf_new = (res_o == '0);
  end
endmodule

// File: rtl/alu4_flags.sv
module alu4_flags
  import alu4_pkg::*;
(
  input  logic      clk,
  input  logic      rst_q_n,
  input  logic      en_i,
  input  flag_upd_t upd_i,
  output logic      cf_o,
  output logic      zf_o
);
  logic cf_q, zf_q, cf_d, zf_d;

  always_comb begin
    cf_d = cf_q;
    zf_d = zf_q;
    if (en_i && upd_i.upd_cf) cf_d = upd_i.cf_new;
    if (en_i && upd_i.upd_zf) zf_d = upd_i.zf_new;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      cf_q <= 1'b0;
      zf_q <= 1'b0;
    end else begin
      cf_q <= cf_d;
      zf_q <= zf_d;
    end
  end

  assign cf_o = cf_q;
  assign zf_o = zf_q;
endmodule

// File: rtl/alu4_flag_unit.sv
module alu4_flag_unit
  import alu4_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_i,
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  acc_i,
  input  logic [DW-1:0]  opnd_i,
  output logic [DW-1:0]  res_o,
  output logic           wr_acc_o,
  output logic           cf_o,
  output logic           zf_o
);
  logic      rst_sync_n;
  logic      writes;
  flag_upd_t upd;

  alu4_rst_sync #(.STAGES(SYNCN)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_sync_n)
  );

  alu4_core #(.W(DW)) u_core (
    .op_i     (op_i),
    .acc_i    (acc_i),
    .opnd_i   (opnd_i),
    .res_o    (res_o),
    .writes_o (writes),
    .upd_o    (upd)
  );

  alu4_flags u_flags (
    .clk     (clk),
    .rst_q_n (rst_sync_n),
    .en_i    (en_i),
    .upd_i   (upd),
    .cf_o    (cf_o),
    .zf_o    (zf_o)
  );

  assign wr_acc_o = en_i & writes;
endmodule

// File: rtl/alu4_flag_unit_chk.sv
module alu4_flag_unit_chk
  import alu4_pkg::*;
(
  input logic           clk,
  input logic           rst_q_n,
  input logic           en_i,
  input logic [OPW-1:0] op_i,
  input logic [DW-1:0]  acc_i,
  input logic [DW-1:0]  opnd_i,
  input logic [DW-1:0]  res_o,
  input logic           wr_acc_o,
  input logic           cf_o,
  input logic           zf_o
);
  logic valid_op;
  assign valid_op = (op_i <= 3'd4);

  AST_RST_CLEAR: assert property (@(posedge clk)
    !rst_q_n |-> (!cf_o && !zf_o)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    !en_i |=> ($stable(cf_o) && $stable(zf_o))); // R7

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_q_n)
    (en_i && valid_op) |=> (zf_o == ($past(res_o) == '0))); // R6

  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_q_n)
    (en_i && op_i == OP_ADD) |=>
      (cf_o == (({1'b0, $past(acc_i)} + {1'b0, $past(opnd_i)}) > 5'd15))); // R3

  AST_SUB_BORROW: assert property (@(posedge clk) disable iff (!rst_q_n)
    (en_i && op_i == OP_SUB) |=> (cf_o == ($past(opnd_i) > $past(acc_i)))); // R4

  AST_CMP_NO_WB: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op_i == OP_CMP) |-> !wr_acc_o); // R5

  AST_PASS_CF_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    (en_i && op_i == OP_PASS) |=> $stable(cf_o)); // R1

  AST_NAND_CF_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    (en_i && op_i == OP_NAND) |=> $stable(cf_o)); // R2

  AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    !valid_op |=> ($stable(cf_o) && $stable(zf_o))); // R9
endmodule

bind alu4_flag_unit alu4_flag_unit_chk u_chk (
  .clk      (clk),
  .rst_q_n  (rst_sync_n),
  .en_i     (en_i),
  .op_i     (op_i),
  .acc_i    (acc_i),
  .opnd_i   (opnd_i),
  .res_o    (res_o),
  .wr_acc_o (wr_acc_o),
  .cf_o     (cf_o),
  .zf_o     (zf_o)
);

// File: tb/alu4_flag_unit_bench.sv
module alu4_flag_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en_i;
  logic [2:0] op_i;
  logic [3:0] acc_i, opnd_i;
  logic [3:0] res_o;
  logic       wr_acc_o, cf_o, zf_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  alu4_flag_unit u_alu4_flag_unit (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .op_i(op_i), .acc_i(acc_i),
    .opnd_i(opnd_i), .res_o(res_o), .wr_acc_o(wr_acc_o), .cf_o(cf_o), .zf_o(zf_o)
  );

  // {op, acc, opnd, en, res, cf, zf, wr}; run in order from cleared flags
  localparam logic [18:0] VEC [16] = '{
    {3'd0, 4'h3, 4'h0, 1'b1, 4'h0, 1'b0, 1'b1, 1'b1},  // R1 load zero
    {3'd2, 4'h1, 4'hF, 1'b1, 4'h0, 1'b1, 1'b1, 1'b1},  // R3 1+F
    {3'd0, 4'h0, 4'h5, 1'b1, 4'h5, 1'b1, 1'b0, 1'b1},  // R1 CF kept
    {3'd1, 4'hF, 4'hF, 1'b1, 4'h0, 1'b1, 1'b1, 1'b1},  // R2 CF kept
    {3'd3, 4'h3, 4'h5, 1'b1, 4'hE, 1'b1, 1'b0, 1'b1},  // R4 borrow
    {3'd3, 4'h5, 4'h5, 1'b1, 4'h0, 1'b0, 1'b1, 1'b1},  // R4 equal
    {3'd4, 4'h2, 4'h7, 1'b1, 4'hB, 1'b1, 1'b0, 1'b0},  // R5
    {3'd4, 4'h9, 4'h9, 1'b1, 4'h0, 1'b0, 1'b1, 1'b0},  // R5
    {3'd2, 4'h7, 4'h8, 1'b0, 4'hF, 1'b0, 1'b1, 1'b0},  // R7 disabled
    {3'd5, 4'h1, 4'h1, 1'b1, 4'h1, 1'b0, 1'b1, 1'b0},  // R9
    {3'd6, 4'h4, 4'h0, 1'b1, 4'h4, 1'b0, 1'b1, 1'b0},  // R9
    {3'd2, 4'h8, 4'h8, 1'b1, 4'h0, 1'b1, 1'b1, 1'b1},  // R3
    {3'd1, 4'hA, 4'h5, 1'b1, 4'hF, 1'b1, 1'b0, 1'b1},  // R2
    {3'd7, 4'h0, 4'h0, 1'b1, 4'h0, 1'b1, 1'b0, 1'b0},  // R9
    {3'd2, 4'hF, 4'h0, 1'b1, 4'hF, 1'b0, 1'b0, 1'b1},  // R3
    {3'd3, 4'h0, 4'h1, 1'b1, 4'hF, 1'b1, 1'b0, 1'b1}   // R4
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, check combinational outputs, then flags after the edge
  task automatic step(input string req, input logic [2:0] op, input logic [3:0] a,
                      input logic [3:0] b, input logic en, input logic [3:0] e_res,
                      input logic e_cf, input logic e_zf, input logic e_wr);
    @(negedge clk);
    op_i = op; acc_i = a; opnd_i = b; en_i = en;
    #1;
    chk({req, " R10 res"}, res_o, e_res);
    chk({req, " wr"}, wr_acc_o, e_wr);
    @(posedge clk);
    #1;
    chk({req, " cf"}, cf_o, e_cf);
    chk({req, " zf"}, zf_o, e_zf);
  endtask

  initial begin
    rst_n = 1'b1; en_i = 1'b0; op_i = '0; acc_i = '0; opnd_i = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset cf", cf_o, 0);
    chk("R8 reset zf", zf_o, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    for (int i = 0; i < 16; i++) begin
      logic [18:0] v;
      v = VEC[i];
      step($sformatf("vec%0d", i), v[18:16], v[15:12], v[11:8], v[7],
           v[6:3], v[2], v[1], v[0]);
    end

    // exhaustive sweep against a behavioural model
    begin
      logic mcf, mzf;
      mcf = cf_o; mzf = zf_o;
      for (int op = 0; op < 5; op++) begin
        for (int a = 0; a < 16; a++) begin
          for (int b = 0; b < 16; b++) begin
            int r;
            logic w;
            case (op)
              0: r = b;
              1: r = (~(a & b)) & 15;
              2: begin r = (a + b) & 15; mcf = (a + b) > 15; end
              default: begin r = (a - b) & 15; mcf = b > a; end
            endcase
            mzf = (r == 0);
            w = (op != 4);
            step($sformatf("sweep op%0d R1 R2 R3 R4 R5 R6", op), op[2:0], a[3:0],
                 b[3:0], 1'b1, r[3:0], mcf, mzf, w);
          end
        end
      end
    end

    // R8: asynchronous assertion between edges, then synchronized release
    @(negedge clk);
    op_i = 3'd2; acc_i = 4'h1; opnd_i = 4'hF; en_i = 1'b1;
    @(posedge clk);
    #5 rst_n = 1'b0;
    #1;
    chk("R8 async clear cf", cf_o, 0);
    chk("R8 async clear zf", zf_o, 0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R8 edge1 held cf", cf_o, 0);
    @(posedge clk); #1;
    chk("R8 edge2 held zf", zf_o, 0);
    @(posedge clk); #1;
    chk("R8 edge3 cf", cf_o, 1);
    chk("R8 edge3 zf", zf_o, 1);

    // R7: long disabled stretch with flag-changing ops
    step("R7 idle sub", 3'd3, 4'h9, 4'h1, 1'b0, 4'h8, 1'b1, 1'b1, 1'b0);
    step("R7 idle pass", 3'd0, 4'h0, 4'h7, 1'b0, 4'h7, 1'b1, 1'b1, 1'b0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule